// File: doc/BRIEF.md
# Partitioned Message Slot Allocator

This block hands out message buffer slots from a shared pool to two kinds of requester: receive (incoming) and transmit (outgoing). Each slot has one used bit. An allocation finds the lowest-numbered free slot in the range its category may use, sets that slot's used bit in the same clock edge, and reports the slot index. If no slot in that range is free, the block reports a failure instead. A free request with a slot index clears that slot's used bit.

Transmit requests may only use the upper three quarters of the pool. The lowest quarter therefore stays reserved for receive buffers. A reply can always be taken in, even when outgoing traffic has used up every slot it is allowed to use. Receive requests may use the whole pool.

If a receive request and a transmit request arrive in the same cycle, only the receive request is served. The transmit requester must keep its request asserted and is served in a later cycle. A free request is applied before the search, so a slot freed in one cycle can be granted in that same cycle.

Top module: `msg_slot_alloc`

## Requirements
- R1: After reset, every slot is free and no grant or failure pulse is present. The first receive allocation gets slot 0, and the first transmit allocation gets slot POOL_SIZE/4.
- R2: A receive allocation (`rx_alloc_req`=1) is granted the lowest-indexed free slot in the range 0 to POOL_SIZE-1.
- R3: A transmit allocation (`tx_alloc_req`=1, `rx_alloc_req`=0) is granted the lowest-indexed free slot in the range POOL_SIZE/4 to POOL_SIZE-1. It is never granted a slot below POOL_SIZE/4.
- R4: A granted slot is marked used on the same edge as the grant. It is not granted again until it has been freed.
- R5: When no slot in the requester's range is free, `alloc_fail` pulses, `alloc_ok` stays 0 and `alloc_slot` reads 0. A transmit request fails when the upper three quarters are full, even if slots in the lowest quarter are free.
- R6: A free request (`free_req`=1) clears the used bit of slot `free_idx` unconditionally. Freeing a slot that is already free has no effect on later grants.
- R7: A free request and an allocation in the same cycle are resolved free-first, so the slot being freed can be granted in that cycle.
- R8: When both request inputs are 1 in one cycle, the receive request is served and reported with `alloc_cat`=0. The transmit request gets neither a grant nor a failure that cycle.
- R9: Results are registered and appear one clock after the request. `alloc_ok` and `alloc_fail` are single-cycle pulses, and never both 1. `alloc_cat` is 1 for transmit and 0 for receive. Without a request, both pulses are 0 and `alloc_slot` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_alloc_req | input | 1 | Request a slot for receive use |
| tx_alloc_req | input | 1 | Request a slot for transmit use |
| free_req | input | 1 | Release the slot given by free_idx |
| free_idx | input | $clog2(POOL_SIZE) | Slot to release |
| alloc_ok | output | 1 | Grant pulse |
| alloc_fail | output | 1 | Failure pulse, no slot in range |
| alloc_slot | output | $clog2(POOL_SIZE) | Granted slot index (0 unless granted) |
| alloc_cat | output | 1 | Category of the served request, 1 = transmit |

## Verification
The bench builds the block with POOL_SIZE = 8. With that size the reserved receive quarter is only slots 0 and 1, so random traffic fills both the transmit range and the whole pool within a few cycles. Failures of both categories, same-cycle free-and-grant on a full pool, and transmit requests that fail while the reserved quarter is still free all occur often, rather than rarely. A bench model of the used bits predicts every grant, and directed sequences pin down the reset state and the ordering corner cases.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

  typedef enum logic {
    CAT_RX = 1'b0,
    CAT_TX = 1'b1
  } slot_cat_e;

  // First index a transmit search may use: the lowest quarter is reserved.
  function automatic int unsigned tx_floor(int unsigned pool);
    return pool / 4;
  endfunction

  // Lowest index of the category's range.
  function automatic int unsigned range_lo(int unsigned pool, slot_cat_e cat);
    return (cat == CAT_TX) ? tx_floor(pool) : 0;
  endfunction

endpackage

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int unsigned N  = 32,
  parameter int unsigned LO = 0,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  output logic          hit,
  output logic [IW-1:0] idx
);

  // Scan from the top down so that the lowest free index is the last one written.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = int'(N) - 1; i >= int'(LO); i--) begin
      if (!busy[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/slot_used_reg.sv
module slot_used_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] used_q
);

  // Clear is applied first, so a slot may be cleared and set on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= (used_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/msg_slot_alloc.sv
module msg_slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int unsigned POOL_SIZE = 32,
  localparam int unsigned IW = $clog2(POOL_SIZE),
  localparam int unsigned TX_LO = POOL_SIZE / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_alloc_req,
  input  logic          tx_alloc_req,
  input  logic          free_req,
  input  logic [IW-1:0] free_idx,
  output logic          alloc_ok,
  output logic          alloc_fail,
  output logic [IW-1:0] alloc_slot,
  output logic          alloc_cat
);

  logic [POOL_SIZE-1:0] used_q;
  logic [POOL_SIZE-1:0] free_oh;
  logic [POOL_SIZE-1:0] grant_oh;
  logic [POOL_SIZE-1:0] busy_view;
  logic [1:0]           cat_hit;
  logic [IW-1:0]        cat_idx [2];
  logic                 any_req;
  slot_cat_e            served_cat;
  logic                 win_hit;
  logic [IW-1:0]        win_idx;
  logic                 grant_now;

  // Release first, then search: a freed slot is visible to this cycle's allocation.
  assign free_oh   = free_req ? (POOL_SIZE'(1) << free_idx) : '0;
  assign busy_view = used_q & ~free_oh;

  // One finder per category, each with its own range floor.
  for (genvar c = 0; c < 2; c++) begin : g_cat
    slot_finder #(
      .N  (POOL_SIZE),
      .LO (range_lo(POOL_SIZE, slot_cat_e'(c)))
    ) u_find (
      .busy (busy_view),
      .hit  (cat_hit[c]),
      .idx  (cat_idx[c])
    );
  end

  // Receive takes precedence when both requests are present.
  assign any_req    = rx_alloc_req | tx_alloc_req;
  assign served_cat = rx_alloc_req ? CAT_RX : CAT_TX;
  assign win_hit    = cat_hit[served_cat];
  assign win_idx    = cat_idx[served_cat];
  assign grant_now  = any_req & win_hit;
  assign grant_oh   = grant_now ? (POOL_SIZE'(1) << win_idx) : '0;

  slot_used_reg #(.N(POOL_SIZE)) u_used (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_vec (free_oh),
    .set_vec (grant_oh),
    .used_q  (used_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ok   <= 1'b0;
      alloc_fail <= 1'b0;
      alloc_slot <= '0;
      alloc_cat  <= 1'b0;
    end else begin
      alloc_ok   <= grant_now;
      alloc_fail <= any_req & ~win_hit;
      alloc_slot <= grant_now ? win_idx : '0;
      alloc_cat  <= any_req ? logic'(served_cat) : 1'b0;
    end
  end

endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
  parameter int unsigned POOL_SIZE = 32,
  localparam int unsigned IW = $clog2(POOL_SIZE),
  localparam int unsigned TX_LO = POOL_SIZE / 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_alloc_req,
  input logic                 tx_alloc_req,
  input logic                 free_req,
  input logic [IW-1:0]        free_idx,
  input logic                 alloc_ok,
  input logic                 alloc_fail,
  input logic [IW-1:0]        alloc_slot,
  input logic                 alloc_cat,
  input logic [POOL_SIZE-1:0] used_q
);

  a_r3_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && alloc_cat) |-> (alloc_slot >= IW'(TX_LO)));

  a_r4_grant_marked: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> used_q[alloc_slot]);

  a_r5_rx_fail_full: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fail && !alloc_cat) |-> (&used_q));

  a_r5_tx_fail_upper_full: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fail && alloc_cat) |-> (&used_q[POOL_SIZE-1:TX_LO]));

  a_r6_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    free_req |=> (!used_q[$past(free_idx)] || (alloc_ok && alloc_slot == $past(free_idx))));

  a_r7_free_then_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (free_req && rx_alloc_req && (&used_q)) |=> (alloc_ok && alloc_slot == $past(free_idx)));

  a_r8_rx_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_alloc_req && tx_alloc_req) |=> !alloc_cat);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_ok && alloc_fail));

  a_r9_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_alloc_req || tx_alloc_req) |=> $countones({alloc_ok, alloc_fail}) == 1);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_alloc_req || tx_alloc_req) |=> (!alloc_ok && !alloc_fail));

endmodule

bind msg_slot_alloc slot_alloc_chk #(.POOL_SIZE(POOL_SIZE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_alloc_req (rx_alloc_req),
  .tx_alloc_req (tx_alloc_req),
  .free_req     (free_req),
  .free_idx     (free_idx),
  .alloc_ok     (alloc_ok),
  .alloc_fail   (alloc_fail),
  .alloc_slot   (alloc_slot),
  .alloc_cat    (alloc_cat),
  .used_q       (used_q)
);

// File: tb/test_msg_slot_alloc.sv
`timescale 1ns/1ps
module test_msg_slot_alloc;
  localparam int P    = 8;
  localparam int IW   = $clog2(P);
  localparam int TXLO = P / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_alloc_req = 1'b0, tx_alloc_req = 1'b0, free_req = 1'b0;
  logic [IW-1:0] free_idx = '0;
  logic alloc_ok, alloc_fail, alloc_cat;
  logic [IW-1:0] alloc_slot;

  int checks = 0;
  int errors = 0;
  bit [P-1:0] model = '0;

  always #2.5 clk = ~clk;

  msg_slot_alloc #(.POOL_SIZE(P)) i_msg_slot_alloc (
    .clk(clk), .rst_n(rst_n),
    .rx_alloc_req(rx_alloc_req), .tx_alloc_req(tx_alloc_req),
    .free_req(free_req), .free_idx(free_idx),
    .alloc_ok(alloc_ok), .alloc_fail(alloc_fail),
    .alloc_slot(alloc_slot), .alloc_cat(alloc_cat)
  );

  // Lowest clear bit at or above lo, or -1 when the range is full.
  function automatic int lowest_clear(bit [P-1:0] m, int lo);
    for (int i = lo; i < P; i++) if (!m[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, bit good, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit rx, bit tx, bit fr, int fi, string tag);
    bit [P-1:0] m;
    int ff, lo;
    bit req, e_ok, e_fail, e_cat;
    int e_slot;
    string t;
    @(negedge clk);
    rx_alloc_req = rx; tx_alloc_req = tx; free_req = fr; free_idx = IW'(fi);
    m = model;
    if (fr) m[fi] = 1'b0;
    req = rx | tx;
    e_cat = req && !rx;
    lo = rx ? 0 : TXLO;
    ff = lowest_clear(m, lo);
    e_ok = req && (ff >= 0);
    e_fail = req && (ff < 0);
    e_slot = e_ok ? ff : 0;
    if (e_ok) m[ff] = 1'b1;
    model = m;
    t = tag;
    if (t == "") t = e_fail ? "R5" : (rx && tx) ? "R8" : tx ? "R3" : rx ? "R2" : "R9";
    @(posedge clk);
    #1;
    check(t, {alloc_ok, alloc_fail, alloc_cat, alloc_slot} == {e_ok, e_fail, e_cat, IW'(e_slot)},
          int'({alloc_ok, alloc_fail, alloc_cat, alloc_slot}),
          int'({e_ok, e_fail, e_cat, IW'(e_slot)}));
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {alloc_ok, alloc_fail} == 2'b00, int'({alloc_ok, alloc_fail}), 0);
    @(negedge clk) rst_n = 1'b1;

    step(1, 0, 0, 0, "R1");            // slot 0
    step(0, 1, 0, 0, "R1");            // slot TXLO
    step(1, 0, 0, 0, "R2");            // slot 1
    step(1, 0, 0, 0, "R4");            // slot 3, skips granted 2
    step(1, 0, 0, 0, "R4");
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");            // pool full now
    step(1, 0, 0, 0, "R5");            // rx fails
    step(0, 0, 1, 0, "R9");            // free slot 0, no pulse
    step(0, 1, 0, 0, "R5");            // tx fails though slot 0 free
    step(1, 0, 0, 0, "R2");            // rx takes slot 0
    step(1, 0, 1, 5, "R7");            // full: free 5 and grant 5
    step(0, 1, 1, 3, "R7");            // free 3 and tx grant 3
    step(1, 1, 0, 0, "R8");            // full: rx fails, tx silent
    for (int i = 0; i < P; i++) step(0, 0, 1, i, "R6");
    step(0, 0, 1, 4, "R6");            // free an already free slot
    step(1, 0, 0, 0, "R6");            // still slot 0
    step(1, 1, 0, 0, "R8");            // rx served: slot 1
    step(0, 1, 0, 0, "R3");            // slot 2

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(99));
      step(r < 40, (r >= 25) && (r < 70), $urandom_range(1) == 1,
           int'($urandom_range(P - 1)), "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule